// File: doc/BRIEF.md
# Multi-Channel Synthesizer Parameter Bank

This block holds the programming for each output channel of a multi-channel digital frequency synthesizer. Every channel has two copies of its rate settings. The staged copy is written from the bus. The active copy drives the synthesizer datapath. The rate settings are a coarse divider, a fine phase step, a power-of-two post divider and a divide-by-3 select.

The active copy changes only on a commit. A commit happens when software raises the channel's commit bit from 0 to 1. It copies all four staged fields into the active set on one clock edge, so a running clock moves to its new frequency without passing through a mix of old and new settings. The datapath derives the output frequency from the active fields as fin·2^20·32 / ((2^20·(32+coarse) + 32·step) · 2^post · k), where k is 3 or 1.

Each channel also has a standby control and a channel reset control. The block reports whether each channel is unprogrammed and whether it is live. To bring a channel up, software stages the rate, clears standby and reset, then pulses the commit bit.

Top module: `synth_prog_bank`

## Requirements
- R1: After reset, every channel shows all active fields at zero, standby asserted (`ch_sleep`=1), channel reset held (`ch_hold`=1), `ch_blank`=1 and `ch_live`=0.
- R2: A write with `wr_sel`=0 loads the staged word of channel `wr_chan` and leaves every active output unchanged. The staged word is laid out as step [14:0], post divider [18:15], coarse divider [23:19] and divide-by-3 select [24].
- R3: A write with `wr_sel`=1 and data bit 0 set, while that channel's stored commit bit is 0, copies all four staged fields to the active outputs at that clock edge.
- R4: A control write with bit 0 set while the stored commit bit is already 1 commits nothing. The bit must be written back to 0 before the next commit.
- R5: A write or commit on one channel never alters another channel's outputs.
- R6: `act_div3_n` carries the committed select bit: 0 selects divide-by-3 and 1 selects divide-by-1.
- R7: Control bit 1 is the run bit. With the default polarity (`RUN_LVL`=1), writing 0 puts the channel in standby (`ch_sleep`=1) and writing 1 takes it out (`ch_sleep`=0).
- R8: Control bit 2 is the channel reset. Writing 1 holds the channel in reset (`ch_hold`=1) and writing 0 releases it.
- R9: `ch_blank` is 1 exactly when the active coarse divider, step and post divider are all zero, whatever the divide-by-3 select is.
- R10: `ch_live` is 1 one cycle after a channel is out of standby, out of reset and not blank, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_chan | input | CH_W | Channel addressed by the write |
| wr_sel | input | 1 | 0: staged rate word, 1: control word |
| wr_data | input | DW | Write data |
| act_md | output | NCH*MD_W | Active coarse dividers, channel 0 in the low bits |
| act_pe | output | NCH*PE_W | Active phase steps |
| act_sdiv | output | NCH*SD_W | Active power-of-two post dividers |
| act_div3_n | output | NCH | Active divide-by-3 select, 0 selects divide-by-3 |
| ch_sleep | output | NCH | Channel in standby |
| ch_hold | output | NCH | Channel held in reset |
| ch_blank | output | NCH | Channel unprogrammed |
| ch_live | output | NCH | Channel running |

## Verification
Several properties are checked on every cycle. A staging write never moves the active set. A fresh commit copies exactly the staged word. A repeated commit while the bit is still set does nothing. The blank flag always matches the active fields, a rising live flag follows from its three conditions, and write strobes are never given to two targets at once. Other behaviours only show up in the bench's scenarios. These are the independence of channels, the field positions within the staged word, the standby polarity, and the full commit sequence followed by bring-up. The bench sweeps the coarse divider across its whole range, with post dividers and select values that vary with it, and checks every channel against its own model after each step.

// File: rtl/synth_pkg.sv
package synth_pkg;
  // control word bit positions; software relies on them
  localparam int CTL_GO   = 0;
  localparam int CTL_RUN  = 1;
  localparam int CTL_HOLD = 2;

  typedef enum logic {
    SEL_STAGE = 1'b0,
    SEL_CTRL  = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/synth_wr_decode.sv
module synth_wr_decode
  import synth_pkg::*;
#(
  parameter int NCH  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_sel,
  output logic [NCH-1:0]  stage_we,
  output logic [NCH-1:0]  ctl_we
);
  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit         = wr_en && (wr_chan == CH_W'(c));
    assign stage_we[c] = hit && (sel == SEL_STAGE);
    assign ctl_we[c]   = hit && (sel == SEL_CTRL);
  end

  // R5
  always_comb begin
    onehot_we_chk: assert ($onehot0({stage_we, ctl_we}));
  end
endmodule

// File: rtl/synth_chan.sv
module synth_chan
  import synth_pkg::*;
#(
  parameter int MD_W    = 5,
  parameter int PE_W    = 15,
  parameter int SD_W    = 4,
  parameter bit RUN_LVL = 1'b1,
  localparam int DW     = PE_W + SD_W + MD_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stage_we,
  input  logic            ctl_we,
  input  logic [DW-1:0]   wdata,
  output logic [MD_W-1:0] act_md,
  output logic [PE_W-1:0] act_pe,
  output logic [SD_W-1:0] act_sdiv,
  output logic            act_div3_n,
  output logic            sleep,
  output logic            hold,
  output logic            blank,
  output logic            live
);
  localparam int SD_LO = PE_W;
  localparam int MD_LO = PE_W + SD_W;
  localparam int D3_B  = DW - 1;

  logic [DW-1:0] stage_q, act_q;
  logic go_q, sleep_q, hold_q, blank_q, live_q;
  logic commit;

  assign commit = ctl_we && wdata[CTL_GO] && !go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      act_q   <= '0;
      go_q    <= 1'b0;
      sleep_q <= 1'b1;
      hold_q  <= 1'b1;
      blank_q <= 1'b1;
      live_q  <= 1'b0;
    end else begin
      if (stage_we) stage_q <= wdata;
      if (ctl_we) begin
        go_q    <= wdata[CTL_GO];
        sleep_q <= (wdata[CTL_RUN] != RUN_LVL);
        hold_q  <= wdata[CTL_HOLD];
      end
      if (commit) begin
        act_q   <= stage_q;
        blank_q <= (stage_q[D3_B-1:0] == '0);
      end
      live_q <= !sleep_q && !hold_q && !blank_q;
    end
  end

  assign act_pe     = act_q[PE_W-1:0];
  assign act_sdiv   = act_q[SD_LO +: SD_W];
  assign act_md     = act_q[MD_LO +: MD_W];
  assign act_div3_n = act_q[D3_B];
  assign sleep      = sleep_q;
  assign hold       = hold_q;
  assign blank      = blank_q;
  assign live       = live_q;

  // R2
  stage_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stage_we |=> $stable(act_q));
  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[CTL_GO] && !go_q) |=> (act_q == $past(stage_q)));
  // R4
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && go_q) |=> $stable(act_q));
  // R9
  blank_match_chk: assert property (@(posedge clk) disable iff (rst)
    blank_q == (act_q[D3_B-1:0] == '0));
  // R10
  live_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(live_q) |-> $past(!sleep_q && !hold_q && !blank_q));
endmodule

// File: rtl/synth_prog_bank.sv
module synth_prog_bank #(
  parameter int NCH     = 4,
  parameter int MD_W    = 5,
  parameter int PE_W    = 15,
  parameter int SD_W    = 4,
  parameter bit RUN_LVL = 1'b1,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW     = PE_W + SD_W + MD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_chan,
  input  logic                 wr_sel,
  input  logic [DW-1:0]        wr_data,
  output logic [NCH*MD_W-1:0]  act_md,
  output logic [NCH*PE_W-1:0]  act_pe,
  output logic [NCH*SD_W-1:0]  act_sdiv,
  output logic [NCH-1:0]       act_div3_n,
  output logic [NCH-1:0]       ch_sleep,
  output logic [NCH-1:0]       ch_hold,
  output logic [NCH-1:0]       ch_blank,
  output logic [NCH-1:0]       ch_live
);
  logic [NCH-1:0] stage_we, ctl_we;

  synth_wr_decode #(.NCH(NCH)) u_dec (
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .wr_sel  (wr_sel),
    .stage_we(stage_we),
    .ctl_we  (ctl_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    synth_chan #(
      .MD_W(MD_W), .PE_W(PE_W), .SD_W(SD_W), .RUN_LVL(RUN_LVL)
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .stage_we  (stage_we[c]),
      .ctl_we    (ctl_we[c]),
      .wdata     (wr_data),
      .act_md    (act_md[c*MD_W +: MD_W]),
      .act_pe    (act_pe[c*PE_W +: PE_W]),
      .act_sdiv  (act_sdiv[c*SD_W +: SD_W]),
      .act_div3_n(act_div3_n[c]),
      .sleep     (ch_sleep[c]),
      .hold      (ch_hold[c]),
      .blank     (ch_blank[c]),
      .live      (ch_live[c])
    );
  end
endmodule

// File: tb/sim_synth_prog_bank.sv
module sim_synth_prog_bank;
  localparam int NCH = 4;
  localparam int DW  = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_chan = '0;
  logic wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [NCH*5-1:0]  act_md;
  logic [NCH*15-1:0] act_pe;
  logic [NCH*4-1:0]  act_sdiv;
  logic [NCH-1:0] act_div3_n, ch_sleep, ch_hold, ch_blank, ch_live;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_stg [NCH];
  logic [DW-1:0] m_act [NCH];
  logic m_go [NCH], m_run [NCH], m_hold [NCH];

  always #2 clk = ~clk;

  synth_prog_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel),
    .wr_data(wr_data), .act_md(act_md), .act_pe(act_pe), .act_sdiv(act_sdiv),
    .act_div3_n(act_div3_n), .ch_sleep(ch_sleep), .ch_hold(ch_hold),
    .ch_blank(ch_blank), .ch_live(ch_live)
  );

  task automatic chk(input bit ok, input string req, input int ch,
                     input string fld, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ch%0d %s got=%0h exp=%0h", req, ch, fld, got, exp);
    end
  endtask

  task automatic wr(input int ch, input bit sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 2'(ch); wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) m_stg[ch] = d;
    else begin
      if (d[0] && !m_go[ch]) m_act[ch] = m_stg[ch];
      m_go[ch] = d[0]; m_run[ch] = d[1]; m_hold[ch] = d[2];
    end
  endtask

  function automatic logic [DW-1:0] pack(int md, int sd, int pe, bit d3n);
    return {d3n, 5'(md), 4'(sd), 15'(pe)};
  endfunction

  // go=1 then go=0, keeping run/hold as given
  task automatic pulse(input int ch, input bit run, input bit hld);
    wr(ch, 1'b1, {22'd0, hld, run, 1'b1});
    wr(ch, 1'b1, {22'd0, hld, run, 1'b0});
  endtask

  task automatic check_all(input string req);
    @(negedge clk); @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      logic bl, lv;
      bl = (m_act[c][23:0] == 24'd0);
      lv = m_run[c] && !m_hold[c] && !bl;
      chk(act_pe[c*15 +: 15] == m_act[c][14:0], req, c, "step",
          int'(act_pe[c*15 +: 15]), int'(m_act[c][14:0]));
      chk(act_sdiv[c*4 +: 4] == m_act[c][18:15], req, c, "post",
          int'(act_sdiv[c*4 +: 4]), int'(m_act[c][18:15]));
      chk(act_md[c*5 +: 5] == m_act[c][23:19], req, c, "coarse",
          int'(act_md[c*5 +: 5]), int'(m_act[c][23:19]));
      chk(act_div3_n[c] == m_act[c][24], req, c, "div3n",
          int'(act_div3_n[c]), int'(m_act[c][24]));
      chk(ch_sleep[c] == !m_run[c], req, c, "sleep",
          int'(ch_sleep[c]), int'(!m_run[c]));
      chk(ch_hold[c] == m_hold[c], req, c, "hold",
          int'(ch_hold[c]), int'(m_hold[c]));
      chk(ch_blank[c] == bl, req, c, "blank", int'(ch_blank[c]), int'(bl));
      chk(ch_live[c] == lv, req, c, "live", int'(ch_live[c]), int'(lv));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_stg[c] = '0; m_act[c] = '0; m_go[c] = 0; m_run[c] = 0; m_hold[c] = 1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // R2: staged writes alone leave active outputs alone
    for (int c = 0; c < NCH; c++) wr(c, 1'b0, pack(c + 3, c + 1, 100 * c + 7, c[0]));
    check_all("R2");

    // R3: commit every channel
    for (int c = 0; c < NCH; c++) pulse(c, 1'b0, 1'b1);
    check_all("R3");

    // R3 R6: sweep coarse divider on channel 0 with varying post/select
    for (int md = 0; md < 32; md++) begin
      wr(0, 1'b0, pack(md, md % 16, (md * 1021) % 32768, md[0]));
      pulse(0, 1'b0, 1'b1);
      check_all("R6");
    end

    // R4: commit bit left high blocks a second commit
    wr(1, 1'b1, {22'd0, 1'b1, 1'b0, 1'b1});
    wr(1, 1'b0, pack(17, 9, 12345, 1'b1));
    wr(1, 1'b1, {22'd0, 1'b1, 1'b0, 1'b1});
    check_all("R4");
    wr(1, 1'b1, {22'd0, 1'b1, 1'b0, 1'b0});
    wr(1, 1'b1, {22'd0, 1'b1, 1'b0, 1'b1});
    check_all("R4");
    wr(1, 1'b1, {22'd0, 1'b1, 1'b0, 1'b0});

    // R5: one channel's commit leaves the others unchanged
    wr(2, 1'b0, pack(31, 15, 32767, 1'b0));
    pulse(2, 1'b0, 1'b1);
    check_all("R5");

    // R9: zero rate fields with select set is still blank
    wr(3, 1'b0, pack(0, 0, 0, 1'b1));
    pulse(3, 1'b1, 1'b0);
    check_all("R9");
    wr(3, 1'b0, pack(0, 0, 1, 1'b1));
    pulse(3, 1'b1, 1'b0);
    check_all("R9");

    // R7 R8 R10: run/hold combinations on a programmed channel
    for (int k = 0; k < 4; k++) begin
      wr(1, 1'b1, {22'd0, k[1], k[0], 1'b0});
      check_all("R10");
    end
    wr(2, 1'b1, {22'd0, 1'b0, 1'b1, 1'b0});
    check_all("R7");
    wr(2, 1'b1, {22'd0, 1'b1, 1'b1, 1'b0});
    check_all("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule